// File: doc/BRIEF.md
# Row-Aware Hold-Grant Output Arbiter

This block picks one winner per cycle among the input ports of a switch that compete for a single output. Each output leads to one DRAM controller. Every input shows a request flag and the bank and row its head packet targets. The arbiter can keep granting the same input, so a core's requests to one row reach the memory controller together and are not interleaved with requests from other cores.

There are three arbitration modes. The mode is latched from a static configuration input while reset is asserted:

- **Round-robin:** the first requester after the last winner wins.
- **Hold-grant:** the last winner keeps top priority whenever it requests again.
- **Row-matching hold-grant:** the last winner keeps top priority only while it targets the same bank and row as its previous grant.

When the holder does not qualify, arbitration falls back to round-robin starting from the input after the last winner.

A two-state machine tracks whether a priority holder exists:
- `ST_FREE` is entered at reset. No grant has been given yet, so nobody holds priority.
- `ST_HELD` means a last winner is recorded.
- The transition CLAIM (`ST_FREE` to `ST_HELD`) happens on the first grant.
- The transition KEEP (`ST_HELD` to `ST_HELD`) happens on every later cycle.
- Only reset returns the machine to `ST_FREE`.

The grant is registered. Requests sampled at a clock edge produce the grant that is visible after that same edge.

Top module: `rowhold_out_arb`

## Requirements
- R1: While reset is asserted, `gnt` is all zeros and `gnt_vld` is 0, even when inputs request. After reset, no input holds priority, and the round-robin search begins at input 0.
- R2: `gnt` is zero or one-hot, and it marks only an input whose `req` bit was set at the edge that produced it.
- R3: If any `req` bit is set at a clock edge, a grant is issued at that edge. `gnt_vld` is 1 and `gnt_idx` gives the index of the granted input.
- R4: In round-robin mode (`cfg_mode` 2'b00), the winner is the first requesting input in increasing index order after the last winner, wrapping from NUM_IN-1 to 0.
- R5: In hold-grant mode (`cfg_mode` 2'b01), the last winner wins again whenever it requests, whatever address it presents.
- R6: In row-matching mode (`cfg_mode` 2'b10), the last winner wins again only if its current address equals the address stored with its last grant. Otherwise the round-robin order of R4 applies.
- R7: Each input's address field is `ADDR_W` = BANK_W+ROW_W bits, with the bank in the upper BANK_W bits. The match in R6 compares the whole field, so the same row in a different bank is not a match.
- R8: The stored winner and its address change only on a cycle with a grant. A cycle with no requests gives no grant and leaves the holder and its address unchanged.
- R9: `cfg_mode` is captured only while `rst_n` is low. The code 2'b11 behaves as round-robin. Changes to `cfg_mode` after reset have no effect.
- R10: In row-matching mode, when the holder loses, the newly granted input's address replaces the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; `cfg_mode` is latched while it is low |
| cfg_mode | input | 2 | Arbitration mode: 00 round-robin, 01 hold-grant, 10 row-matching hold-grant, 11 round-robin |
| req | input | NUM_IN | Per-input request flags |
| req_addr | input | NUM_IN*ADDR_W | Bank and row for each input; input i occupies bits [i*ADDR_W +: ADDR_W] |
| gnt | output | NUM_IN | Registered one-hot grant |
| gnt_vld | output | 1 | A grant was issued at the last edge |
| gnt_idx | output | IDX_W | Index of the most recent winner |

## Verification
The bench applies the following input patterns:
- **All inputs requesting, repeatedly.** In round-robin mode this shows the rotation and the wrap.
- **Sparse request masks.** These show that the search skips idle inputs and starts after the last winner.
- **Hold-grant with the holder's address changed.** This separates hold-grant from row-matching mode.
- **Row-matching with a changed row, then a changed bank and unchanged row.** These show that losing the hold hands the grant to round-robin order and that the bank bits take part in the match.
- **Idle cycles between grants.** These show that the holder survives cycles without a grant.
- **Reserved mode code, and a mode change after reset.** These show that the mode is latched at reset.

// File: rtl/rha_pkg.sv
package rha_pkg;

    typedef enum logic [1:0] {
        MODE_RR      = 2'b00,
        MODE_HOLD    = 2'b01,
        MODE_ROWHOLD = 2'b10,
        MODE_RSVD    = 2'b11
    } arb_mode_e;

    typedef enum logic {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/rha_rr_pick.sv
module rha_rr_pick #(
    parameter int NUM_IN = 4,
    localparam int IDX_W = $clog2(NUM_IN)
) (
    input  logic [NUM_IN-1:0] req,
    input  logic [IDX_W-1:0]  start_idx,
    output logic              found,
    output logic [IDX_W-1:0]  win_idx
);

    // Rotating search: first requester at or after start_idx, wrapping.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            int c;
            c = int'(start_idx) + k;
            if (c >= NUM_IN) begin
                c = c - NUM_IN;
            end
            if (!found && req[c]) begin
                found   = 1'b1;
                win_idx = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/rha_hold_qual.sv
module rha_hold_qual
    import rha_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int ADDR_W = 8,
    localparam int IDX_W = $clog2(NUM_IN)
) (
    input  arb_mode_e                  mode,
    input  hold_state_e                state,
    input  logic [NUM_IN-1:0]          req,
    input  logic [NUM_IN*ADDR_W-1:0]   req_addr,
    input  logic [IDX_W-1:0]           last_idx,
    input  logic [ADDR_W-1:0]          last_addr,
    output logic                       holder_ok
);

    logic [ADDR_W-1:0] addr_arr [NUM_IN];

    for (genvar i = 0; i < NUM_IN; i++) begin : g_unpack
        assign addr_arr[i] = req_addr[i*ADDR_W +: ADDR_W];
    end

    logic holder_req;
    logic addr_match;

    assign holder_req = (state == ST_HELD) && req[last_idx];
    // Full bank+row compare: same row in another bank is not a match.
    assign addr_match = (addr_arr[last_idx] == last_addr);

    always_comb begin
        unique case (mode)
            MODE_HOLD:    holder_ok = holder_req;
            MODE_ROWHOLD: holder_ok = holder_req && addr_match;
            default:      holder_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/rowhold_out_arb.sv
module rowhold_out_arb
    import rha_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 6,
    localparam int ADDR_W = BANK_W + ROW_W,
    localparam int IDX_W  = $clog2(NUM_IN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                cfg_mode,
    input  logic [NUM_IN-1:0]         req,
    input  logic [NUM_IN*ADDR_W-1:0]  req_addr,
    output logic [NUM_IN-1:0]         gnt,
    output logic                      gnt_vld,
    output logic [IDX_W-1:0]          gnt_idx
);

    localparam logic [IDX_W-1:0] LAST_IN = IDX_W'(NUM_IN - 1);

    arb_mode_e         mode_q;
    hold_state_e       st_q, st_d;
    logic [IDX_W-1:0]  last_q;
    logic [ADDR_W-1:0] last_addr_q;
    logic [NUM_IN-1:0] gnt_q, gnt_d;
    logic              vld_q;

    logic [ADDR_W-1:0] addr_arr [NUM_IN];
    for (genvar i = 0; i < NUM_IN; i++) begin : g_unpack
        assign addr_arr[i] = req_addr[i*ADDR_W +: ADDR_W];
    end

    logic any_req;
    assign any_req = |req;

    // Mode latch: follows cfg_mode only during reset (R9).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= arb_mode_e'(cfg_mode);
        end
    end

    // Holder qualification.
    logic holder_ok;
    rha_hold_qual #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_qual (
        .mode      (mode_q),
        .state     (st_q),
        .req       (req),
        .req_addr  (req_addr),
        .last_idx  (last_q),
        .last_addr (last_addr_q),
        .holder_ok (holder_ok)
    );

    // Round-robin fallback, starting after the last winner.
    logic [IDX_W-1:0] rr_start;
    logic             rr_found;
    logic [IDX_W-1:0] rr_idx;
    assign rr_start = (last_q == LAST_IN) ? '0 : last_q + 1'b1;

    rha_rr_pick #(.NUM_IN(NUM_IN)) u_rr (
        .req       (req),
        .start_idx (rr_start),
        .found     (rr_found),
        .win_idx   (rr_idx)
    );

    logic [IDX_W-1:0] win_idx;
    assign win_idx = holder_ok ? last_q : rr_idx;

    always_comb begin
        gnt_d = '0;
        if (any_req) begin
            gnt_d[win_idx] = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: CLAIM on first grant, KEEP afterwards.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FREE: if (any_req) st_d = ST_HELD;
            ST_HELD: st_d = ST_HELD;
            default: st_d = ST_FREE;
        endcase
    end

    // Output and holder registers: update only on a grant (R8).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q       <= '0;
            vld_q       <= 1'b0;
            last_q      <= LAST_IN;
            last_addr_q <= '0;
        end else begin
            gnt_q <= gnt_d;
            vld_q <= any_req;
            if (any_req) begin
                last_q      <= win_idx;
                last_addr_q <= addr_arr[win_idx];
            end
        end
    end

    assign gnt     = gnt_q;
    assign gnt_vld = vld_q;
    assign gnt_idx = last_q;

    // ---------------- assertions ----------------
    logic [NUM_IN-1:0] last_oh;
    always_comb begin
        last_oh         = '0;
        last_oh[last_q] = 1'b1;
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r2_only_req: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> ((gnt & ~$past(req)) == '0));

    a_r3_work_cons: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> (gnt_vld && (|gnt)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && st_q == ST_HELD && req[last_q])
        |=> (gnt == $past(last_oh)));

    a_r6_rowhold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ROWHOLD && st_q == ST_HELD && req[last_q]
         && addr_arr[last_q] == last_addr_q)
        |=> (gnt == $past(last_oh)));

    a_r8_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (gnt == '0 && $stable(last_q) && $stable(last_addr_q)));

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q));

endmodule

// File: tb/tb_rowhold_out_arb.sv
`timescale 1ns/1ps
module tb_rowhold_out_arb;

    localparam int NUM_IN = 4;
    localparam int NVEC   = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [3:0]  req = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  gnt;
    logic        gnt_vld;
    logic [1:0]  gnt_idx;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rowhold_out_arb #(.NUM_IN(NUM_IN), .BANK_W(2), .ROW_W(6)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .req(req),
        .req_addr(req_addr), .gnt(gnt), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    // {reset, mode, req, addr{a3,a2,a1,a0}, expected gnt}
    localparam logic [42:0] TBL [NVEC] = '{
        {1'b1, 2'd0, 4'b1111, 32'h0,         4'b0001}, // R1 R4 start at 0
        {1'b0, 2'd0, 4'b1111, 32'h0,         4'b0010}, // R4
        {1'b0, 2'd0, 4'b1111, 32'h0,         4'b0100}, // R4
        {1'b0, 2'd0, 4'b1111, 32'h0,         4'b1000}, // R4
        {1'b0, 2'd0, 4'b1111, 32'h0,         4'b0001}, // R4 wrap
        {1'b0, 2'd0, 4'b1010, 32'h0,         4'b0010}, // R4 skip idle
        {1'b0, 2'd0, 4'b1010, 32'h0,         4'b1000}, // R4
        {1'b0, 2'd0, 4'b0000, 32'h0,         4'b0000}, // R8 idle
        {1'b0, 2'd0, 4'b0101, 32'h0,         4'b0001}, // R4 after wrap
        {1'b1, 2'd1, 4'b1110, 32'h0,         4'b0010}, // R1 R5
        {1'b0, 2'd1, 4'b1110, 32'h5A5A5A5A,  4'b0010}, // R5 new addr still held
        {1'b0, 2'd1, 4'b1100, 32'h0,         4'b0100}, // R5 holder absent
        {1'b0, 2'd1, 4'b1111, 32'h0,         4'b0100}, // R5
        {1'b0, 2'd1, 4'b0000, 32'h0,         4'b0000}, // R8
        {1'b0, 2'd1, 4'b1111, 32'h0,         4'b0100}, // R8 hold survives idle
        {1'b0, 2'd1, 4'b1011, 32'h0,         4'b1000}, // R5 fallback
        {1'b1, 2'd2, 4'b0011, 32'h00002211,  4'b0001}, // R6
        {1'b0, 2'd2, 4'b0011, 32'h00002211,  4'b0001}, // R6 same row
        {1'b0, 2'd2, 4'b0011, 32'h00002212,  4'b0010}, // R6 new row loses
        {1'b0, 2'd2, 4'b0011, 32'h00002211,  4'b0010}, // R10 row 0x22 stored
        {1'b0, 2'd2, 4'b0011, 32'h00006211,  4'b0001}, // R7 bank differs
        {1'b0, 2'd2, 4'b0011, 32'h00002211,  4'b0001}, // R10
        {1'b0, 2'd2, 4'b0000, 32'h00002211,  4'b0000}, // R8
        {1'b0, 2'd2, 4'b0011, 32'h00002211,  4'b0001}, // R8 row kept
        {1'b1, 2'd3, 4'b0011, 32'h0,         4'b0001}, // R9 code 11
        {1'b0, 2'd3, 4'b0011, 32'h0,         4'b0010}, // R9 no hold
        {1'b1, 2'd1, 4'b0011, 32'h0,         4'b0001}, // R9
        {1'b0, 2'd0, 4'b0011, 32'h0,         4'b0001}  // R9 late change ignored
    };

    localparam int TAG [NVEC] = '{1,4,4,4,4,4,4,8,4, 5,5,5,5,8,8,5,
                                  6,6,6,10,7,10,8,8, 9,9,9,9};

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst_n    = 1'b0;
        cfg_mode = m;
        req      = 4'b1111;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (gnt !== 4'b0000 || gnt_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: gnt=%b vld=%b expected gnt=0000 vld=0", gnt, gnt_vld);
        end
        rst_n = 1'b1;
        req   = 4'b0000;
    endtask

    function automatic logic [1:0] idx_of(input logic [3:0] oh);
        for (int k = 0; k < 4; k++) begin
            if (oh[k]) return 2'(k);
        end
        return 2'd0;
    endfunction

    initial begin
        for (int i = 0; i < NVEC; i++) begin
            logic [42:0] v;
            v = TBL[i];
            if (v[42]) do_reset(v[41:40]);
            cfg_mode = v[41:40];
            req      = v[39:36];
            req_addr = v[35:4];
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (gnt !== v[3:0] || gnt_vld !== (|v[3:0]) ||
                ((|v[3:0]) && gnt_idx !== idx_of(v[3:0]))) begin
                fails++;
                $display("FAIL R%0d vec %0d: gnt=%b vld=%b idx=%0d expected gnt=%b",
                         TAG[i], i, gnt, gnt_vld, gnt_idx, v[3:0]);
            end
        end
        // Directed R3/R2: single requester at top index in round-robin.
        do_reset(2'b00);
        req = 4'b1000;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (gnt !== 4'b1000 || gnt_idx !== 2'd3 || gnt_vld !== 1'b1) begin
            fails++;
            $display("FAIL R3 single top requester: gnt=%b idx=%0d expected 1000 idx 3", gnt, gnt_idx);
        end
        req = 4'b0000;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule